// File: doc/BRIEF.md
# Clock Generator Mode Controller

This block is the control state machine for a clock generator that has several operating modes. A two-bit select field asks for a mode. Status from the oscillator and the DCO then decides which mode is actually reached. The block runs on the always-on control clock. It drives the enables of the clock generators, the enable of the clock feed to the rest of the chip, and the gate on writes to the DCO frequency code. It also qualifies a crystal reference by counting its edges before the reference may drive the output. The analog DCO, the loop filter and the clock multiplexers sit outside the block. They appear here only as enables and status signals.

The block handles stop mode. A stop request turns the clocks off unless debug is active. A keep-alive bit leaves the generators running while the clock feed is gated. There are two ways out of stop. An interrupt exit keeps the stored configuration. A reset exit restores the defaults, except for the trim value. The reference-domain status inputs (DCO stable, reference detected, loss of clock and the reference clock itself) each pass through a two-stage synchronizer.

Top module: `cgm_ctrl`

## Requirements
- R1: After `rst_n` is released, `mode_o` is 0 (self-clocked), `sel_o` is 00, `dco_code_o` equals DCO_DEFAULT, `div_sel_o` equals DIV_DEFAULT, `ext_valid_o` is 0 and `clk_feed_en_o` is 1.
- R2: `mode_o` encodes the modes as 0 = self-clocked, 1 = FLL engaged internal, 2 = FLL bypassed external, 3 = FLL engaged external, 4 = off. The select field `sel_o` uses 00 = self-clocked, 01 = engaged internal, 10 = bypassed external, 11 = engaged external. A select of 01 or 11 reaches its mode only while DCO stable is 1; until then the mode stays 0. A select of 00 always gives mode 0.
- R3: A reference counts as lost when reference-detected is 0 and loss-of-clock is 1. When the select is 10 or 11 and the reference is lost, the mode is 0.
- R4: A write to `flt_wr_i` loads `dco_code_o` and pulses `flt_we_o` only while the mode is 0. In every other mode the write is ignored and `dco_code_o` keeps its value.
- R5: A stop request with debug inactive and the keep-alive bit clear moves to mode 4. In mode 4, `clk_feed_en_o`, `dco_en_o` and `osc_en_o` are all 0.
- R6: A stop request while `dbg_act_i` is 1 is ignored. The mode and `clk_feed_en_o` are unchanged.
- R7: With the keep-alive bit set, a stop request still enters mode 4 and turns `clk_feed_en_o` off. `dco_en_o` stays 1, and `osc_en_o` stays equal to select bit 1.
- R8: An interrupt exit from mode 4 keeps the select, the divider and the keep-alive bit. A select of 10 resumes mode 2, with `clk_feed_en_o` held at 0 until `ext_valid_o` is 1. Any other select resumes mode 0, and the selected mode is then reached once the conditions of R2 and R3 are met.
- R9: A reset exit from stop gives mode 0 and restores the select to 00, `dco_code_o` to DCO_DEFAULT, `div_sel_o` to DIV_DEFAULT and the keep-alive bit to 0. `trim_o` keeps its value.
- R10: `ext_valid_o` sets only after EDGE_CNT (4096) edges of the synchronized reference clock have been counted with `osc_en_o` at 1 and loss-of-clock at 0. It clears when the oscillator is disabled or loss-of-clock asserts.
- R11: `div_sel_o` carries the divisor R last written with `cfg_wr_i`.
- R12: `ref_src_ext_o` is 1 only in modes 2 and 3 with `ext_valid_o` at 1. In mode 3 without a valid reference it is 0 and the clock feed stays on, driven from the internal reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low power-on reset |
| cfg_wr_i | input | 1 | Write strobe for select, divisor and keep-alive |
| cfg_sel_i | input | 2 | Mode select value to write |
| cfg_div_i | input | DIV_W | Output divisor R to write |
| cfg_keep_i | input | 1 | Keep-alive-in-stop bit to write |
| flt_wr_i | input | 1 | DCO frequency code write request |
| flt_data_i | input | DCO_W | DCO frequency code |
| trim_wr_i | input | 1 | Trim write strobe |
| trim_data_i | input | TRIM_W | Trim value |
| stop_req_i | input | 1 | Stop mode request pulse |
| stop_exit_int_i | input | 1 | Stop exit by interrupt pulse |
| stop_exit_rst_i | input | 1 | Stop exit by reset pulse |
| dbg_act_i | input | 1 | Debug active |
| dco_stable_i | input | 1 | DCO stable status (asynchronous) |
| ext_det_i | input | 1 | External reference detected (asynchronous) |
| loss_clk_i | input | 1 | Loss of clock (asynchronous) |
| ref_clk_i | input | 1 | External reference clock sampled for edge counting |
| mode_o | output | 3 | Current mode |
| sel_o | output | 2 | Stored mode select |
| clk_feed_en_o | output | 1 | System clock feed enable |
| dco_en_o | output | 1 | DCO generator enable |
| osc_en_o | output | 1 | Oscillator generator enable |
| flt_we_o | output | 1 | Accepted DCO code write |
| dco_code_o | output | DCO_W | Current DCO frequency code |
| trim_o | output | TRIM_W | Stored trim value |
| ext_valid_o | output | 1 | External reference qualified |
| ref_src_ext_o | output | 1 | Output is driven from the external reference |
| div_sel_o | output | DIV_W | Output divisor select R |

## Verification
The bench checks that select 01 and 11 wait for DCO stable. A design that ignored this would engage the loop on an unsettled DCO. It checks that a lost reference forces self-clocked mode; a faulty design would keep driving a dead clock. It walks through debug-held stop and keep-alive stop, and compares the two stop exits to confirm that only the reset exit discards the configuration and that the trim survives it. A design that mixed these up would come back at the wrong frequency. The edge counter is checked on both sides of 4096 edges and cleared by loss of clock, so a design that qualified the reference early or kept a stale valid flag is caught. A random sweep of selects and status checks that filter writes land only in self-clocked mode.

// File: rtl/cgm_pkg.sv
package cgm_pkg;
    typedef enum logic [2:0] {
        CGM_SCM = 3'd0,
        CGM_FEI = 3'd1,
        CGM_FBE = 3'd2,
        CGM_FEE = 3'd3,
        CGM_OFF = 3'd4
    } cgm_mode_e;

    localparam int SEL_W = 2;
endpackage

// File: rtl/cgm_sync.sv
module cgm_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/cgm_edge_qual.sv
module cgm_edge_qual #(
    parameter int EDGE_CNT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic ref_i,
    output logic valid_o
);
    localparam int CW = $clog2(EDGE_CNT + 1);
    localparam logic [CW-1:0] LAST = CW'(EDGE_CNT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ref_prev;
        logic          valid;
    } qual_t;

    qual_t q_d, q_q;

    always_comb begin
        q_d          = q_q;
        q_d.ref_prev = ref_i;
        if (!en_i) begin
            q_d.cnt   = '0;
            q_d.valid = 1'b0;
        end else if (!q_q.valid && (ref_i != q_q.ref_prev)) begin
            if (q_q.cnt == LAST) q_d.valid = 1'b1;
            else                 q_d.cnt   = q_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign valid_o = q_q.valid;

    // R10
    disabled_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !valid_o);

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.cnt <= LAST);
endmodule

// File: rtl/cgm_mode_fsm.sv
module cgm_mode_fsm
    import cgm_pkg::*;
#(
    parameter int               DCO_W       = 9,
    parameter int               TRIM_W      = 8,
    parameter int               DIV_W       = 3,
    parameter logic [DCO_W-1:0] DCO_DEFAULT = 9'd64,
    parameter logic [DIV_W-1:0] DIV_DEFAULT = 3'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic [SEL_W-1:0]  cfg_sel_i,
    input  logic [DIV_W-1:0]  cfg_div_i,
    input  logic              cfg_keep_i,
    input  logic              flt_wr_i,
    input  logic [DCO_W-1:0]  flt_data_i,
    input  logic              trim_wr_i,
    input  logic [TRIM_W-1:0] trim_data_i,
    input  logic              stop_req_i,
    input  logic              stop_exit_int_i,
    input  logic              stop_exit_rst_i,
    input  logic              dbg_act_i,
    input  logic              dco_stable_s_i,
    input  logic              ext_det_s_i,
    input  logic              loss_s_i,
    input  logic              ext_valid_i,
    output cgm_mode_e         mode_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              clk_feed_en_o,
    output logic              dco_en_o,
    output logic              osc_en_o,
    output logic              flt_we_o,
    output logic [DCO_W-1:0]  dco_code_o,
    output logic [TRIM_W-1:0] trim_o,
    output logic              ref_src_ext_o,
    output logic [DIV_W-1:0]  div_sel_o
);
    typedef struct packed {
        cgm_mode_e         st;
        logic [SEL_W-1:0]  sel;
        logic [DIV_W-1:0]  div;
        logic              keep;
        logic [DCO_W-1:0]  dco;
        logic [TRIM_W-1:0] trim;
    } fsm_t;

    fsm_t r_d, r_q;
    logic lost;

    assign lost = !ext_det_s_i && loss_s_i;

    function automatic cgm_mode_e target_mode(input logic [SEL_W-1:0] sel,
                                              input logic dco_ok,
                                              input logic ref_lost);
        case (sel)
            2'b01:   target_mode = dco_ok ? CGM_FEI : CGM_SCM;
            2'b10:   target_mode = ref_lost ? CGM_SCM : CGM_FBE;
            2'b11:   target_mode = (dco_ok && !ref_lost) ? CGM_FEE : CGM_SCM;
            default: target_mode = CGM_SCM;
        endcase
    endfunction

    always_comb begin
        r_d = r_q;
        if (trim_wr_i) r_d.trim = trim_data_i;
        if (stop_exit_rst_i) begin
            r_d.st   = CGM_SCM;
            r_d.sel  = '0;
            r_d.div  = DIV_DEFAULT;
            r_d.keep = 1'b0;
            r_d.dco  = DCO_DEFAULT;
        end else begin
            if (cfg_wr_i) begin
                r_d.sel  = cfg_sel_i;
                r_d.div  = cfg_div_i;
                r_d.keep = cfg_keep_i;
            end
            if (r_q.st == CGM_SCM && flt_wr_i) r_d.dco = flt_data_i;
            if (r_q.st == CGM_OFF) begin
                if (stop_exit_int_i)
                    r_d.st = (r_q.sel == 2'b10) ? CGM_FBE : CGM_SCM;
            end else if (stop_req_i && !dbg_act_i) begin
                r_d.st = CGM_OFF;
            end else begin
                r_d.st = target_mode(r_d.sel, dco_stable_s_i, lost);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= CGM_SCM;
            r_q.sel  <= '0;
            r_q.div  <= DIV_DEFAULT;
            r_q.keep <= 1'b0;
            r_q.dco  <= DCO_DEFAULT;
            r_q.trim <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mode_o        = r_q.st;
        sel_o         = r_q.sel;
        div_sel_o     = r_q.div;
        dco_code_o    = r_q.dco;
        trim_o        = r_q.trim;
        flt_we_o      = flt_wr_i && (r_q.st == CGM_SCM);
        ref_src_ext_o = ((r_q.st == CGM_FBE) || (r_q.st == CGM_FEE)) && ext_valid_i;
        case (r_q.st)
            CGM_OFF: begin
                clk_feed_en_o = 1'b0;
                dco_en_o      = r_q.keep;
                osc_en_o      = r_q.keep && r_q.sel[1];
            end
            CGM_FBE: begin
                clk_feed_en_o = ext_valid_i;
                dco_en_o      = 1'b1;
                osc_en_o      = r_q.sel[1];
            end
            default: begin
                clk_feed_en_o = 1'b1;
                dco_en_o      = 1'b1;
                osc_en_o      = r_q.sel[1];
            end
        endcase
    end

    // R3
    lost_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && r_q.st != CGM_OFF && !stop_req_i)
        |=> (mode_o != CGM_FBE && mode_o != CGM_FEE));

    // R4
    flt_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != CGM_SCM && !stop_exit_rst_i) |=> $stable(dco_code_o));

    // R5
    stop_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != CGM_OFF && stop_req_i && !dbg_act_i && !stop_exit_rst_i)
        |=> (mode_o == CGM_OFF && !clk_feed_en_o));

    // R6
    dbg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != CGM_OFF && stop_req_i && dbg_act_i) |=> mode_o != CGM_OFF);

    // R9
    rst_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_exit_rst_i |=> (mode_o == CGM_SCM && sel_o == 2'b00
                             && dco_code_o == DCO_DEFAULT && $stable(trim_o)));
endmodule

// File: rtl/cgm_ctrl.sv
module cgm_ctrl
    import cgm_pkg::*;
#(
    parameter int               DCO_W       = 9,
    parameter int               TRIM_W      = 8,
    parameter int               DIV_W       = 3,
    parameter logic [DCO_W-1:0] DCO_DEFAULT = 9'd64,
    parameter logic [DIV_W-1:0] DIV_DEFAULT = 3'd0,
    parameter int               EDGE_CNT    = 4096,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [DIV_W-1:0]  cfg_div_i,
    input  logic              cfg_keep_i,
    input  logic              flt_wr_i,
    input  logic [DCO_W-1:0]  flt_data_i,
    input  logic              trim_wr_i,
    input  logic [TRIM_W-1:0] trim_data_i,
    input  logic              stop_req_i,
    input  logic              stop_exit_int_i,
    input  logic              stop_exit_rst_i,
    input  logic              dbg_act_i,
    input  logic              dco_stable_i,
    input  logic              ext_det_i,
    input  logic              loss_clk_i,
    input  logic              ref_clk_i,
    output logic [2:0]        mode_o,
    output logic [1:0]        sel_o,
    output logic              clk_feed_en_o,
    output logic              dco_en_o,
    output logic              osc_en_o,
    output logic              flt_we_o,
    output logic [DCO_W-1:0]  dco_code_o,
    output logic [TRIM_W-1:0] trim_o,
    output logic              ext_valid_o,
    output logic              ref_src_ext_o,
    output logic [DIV_W-1:0]  div_sel_o
);
    localparam int NSTAT = 4;

    logic [NSTAT-1:0] stat_s;
    logic             ext_valid;
    logic             osc_en;
    cgm_mode_e        mode;

    cgm_sync #(.W(NSTAT), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ref_clk_i, loss_clk_i, ext_det_i, dco_stable_i}),
        .sync_o  (stat_s)
    );

    cgm_edge_qual #(.EDGE_CNT(EDGE_CNT)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (osc_en && !stat_s[2]),
        .ref_i   (stat_s[3]),
        .valid_o (ext_valid)
    );

    cgm_mode_fsm #(
        .DCO_W(DCO_W), .TRIM_W(TRIM_W), .DIV_W(DIV_W),
        .DCO_DEFAULT(DCO_DEFAULT), .DIV_DEFAULT(DIV_DEFAULT)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_wr_i        (cfg_wr_i),
        .cfg_sel_i       (cfg_sel_i),
        .cfg_div_i       (cfg_div_i),
        .cfg_keep_i      (cfg_keep_i),
        .flt_wr_i        (flt_wr_i),
        .flt_data_i      (flt_data_i),
        .trim_wr_i       (trim_wr_i),
        .trim_data_i     (trim_data_i),
        .stop_req_i      (stop_req_i),
        .stop_exit_int_i (stop_exit_int_i),
        .stop_exit_rst_i (stop_exit_rst_i),
        .dbg_act_i       (dbg_act_i),
        .dco_stable_s_i  (stat_s[0]),
        .ext_det_s_i     (stat_s[1]),
        .loss_s_i        (stat_s[2]),
        .ext_valid_i     (ext_valid),
        .mode_o          (mode),
        .sel_o           (sel_o),
        .clk_feed_en_o   (clk_feed_en_o),
        .dco_en_o        (dco_en_o),
        .osc_en_o        (osc_en),
        .flt_we_o        (flt_we_o),
        .dco_code_o      (dco_code_o),
        .trim_o          (trim_o),
        .ref_src_ext_o   (ref_src_ext_o),
        .div_sel_o       (div_sel_o)
    );

    assign mode_o      = mode;
    assign osc_en_o    = osc_en;
    assign ext_valid_o = ext_valid;

    // R12
    ref_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_src_ext_o |-> (ext_valid_o && (mode_o == 3'd2 || mode_o == 3'd3)));

    // R10
    loss_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_s[2] |=> !ext_valid_o);
endmodule

// File: tb/cgm_ctrl_tb_top.sv
module cgm_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [8:0] DCO_DEF = 9'd64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 0, cfg_keep = 0, flt_wr = 0, trim_wr = 0;
    logic [1:0] cfg_sel = 0;
    logic [2:0] cfg_div = 0;
    logic [8:0] flt_data = 0;
    logic [7:0] trim_data = 0;
    logic stop_req = 0, exit_int = 0, exit_rst = 0, dbg = 0;
    logic dco_stable = 0, ext_det = 0, loss = 0, ref_clk = 0, ref_run = 0;

    logic [2:0] mode;
    logic [1:0] sel;
    logic feed, dco_en, osc_en, flt_we, ext_valid, ref_src;
    logic [8:0] dco_code;
    logic [7:0] trim;
    logic [2:0] div_sel;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) if (ref_run) ref_clk <= ~ref_clk;

    cgm_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel),
        .cfg_div_i(cfg_div), .cfg_keep_i(cfg_keep), .flt_wr_i(flt_wr),
        .flt_data_i(flt_data), .trim_wr_i(trim_wr), .trim_data_i(trim_data),
        .stop_req_i(stop_req), .stop_exit_int_i(exit_int), .stop_exit_rst_i(exit_rst),
        .dbg_act_i(dbg), .dco_stable_i(dco_stable), .ext_det_i(ext_det),
        .loss_clk_i(loss), .ref_clk_i(ref_clk), .mode_o(mode), .sel_o(sel),
        .clk_feed_en_o(feed), .dco_en_o(dco_en), .osc_en_o(osc_en),
        .flt_we_o(flt_we), .dco_code_o(dco_code), .trim_o(trim),
        .ext_valid_o(ext_valid), .ref_src_ext_o(ref_src), .div_sel_o(div_sel)
    );

    function automatic int exp_mode(input logic [1:0] s, input logic ds,
                                    input logic det, input logic ls);
        logic lost;
        lost = !det && ls;
        case (s)
            2'b01:   exp_mode = ds ? 1 : 0;
            2'b10:   exp_mode = lost ? 0 : 2;
            2'b11:   exp_mode = (ds && !lost) ? 3 : 0;
            default: exp_mode = 0;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [1:0] s, input logic [2:0] d, input logic k);
        cfg_sel = s; cfg_div = d; cfg_keep = k; cfg_wr = 1;
        cyc(1); cfg_wr = 0;
    endtask

    task automatic pulse_stop();
        stop_req = 1; cyc(1); stop_req = 0; cyc(1);
    endtask

    initial begin
        int exp_dco;
        cyc(3);
        rst_n = 1;
        cyc(2);
        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 sel", sel, 0);
        chk("R1 dco", dco_code, DCO_DEF);
        chk("R1 div", div_sel, 0);
        chk("R1 ext_valid", ext_valid, 0);
        chk("R1 feed", feed, 1);

        // R11 divisor
        wr_cfg(2'b00, 3'd5, 0);
        chk("R11 div", div_sel, 5);

        // R4 filter write in self-clocked mode
        flt_data = 9'd200; flt_wr = 1;
        #1 chk("R4 we scm", flt_we, 1);
        cyc(1); flt_wr = 0;
        chk("R4 dco scm", dco_code, 200);

        // R2 select 01 waits for DCO stable
        wr_cfg(2'b01, 3'd5, 0);
        cyc(5);
        chk("R2 fei unstable", mode, 0);
        dco_stable = 1; cyc(5);
        chk("R2 fei stable", mode, 1);
        flt_data = 9'd33; flt_wr = 1;
        #1 chk("R4 we fei", flt_we, 0);
        cyc(1); flt_wr = 0;
        chk("R4 dco fei", dco_code, 200);
        wr_cfg(2'b00, 3'd5, 0); cyc(2);
        chk("R2 back scm", mode, 0);

        // R10 / R8 / R12 bypassed external with edge qualification
        ext_det = 1; loss = 0; cyc(4);
        wr_cfg(2'b10, 3'd5, 0); cyc(4);
        chk("R2 fbe", mode, 2);
        chk("R8 fbe feed gated", feed, 0);
        ref_run = 1;
        cyc(4000);
        chk("R10 early", ext_valid, 0);
        cyc(150);
        chk("R10 qualified", ext_valid, 1);
        chk("R8 fbe feed on", feed, 1);
        chk("R12 src ext", ref_src, 1);

        // R3 loss of reference
        ext_det = 0; loss = 1; cyc(5);
        chk("R3 fallback", mode, 0);
        chk("R10 loss clears", ext_valid, 0);
        chk("R12 src scm", ref_src, 0);
        ext_det = 1; loss = 0; ref_run = 0; cyc(4);

        // R5 plain stop
        wr_cfg(2'b00, 3'd5, 0); cyc(2);
        pulse_stop();
        chk("R5 mode", mode, 4);
        chk("R5 feed", feed, 0);
        chk("R5 dco_en", dco_en, 0);
        chk("R5 osc_en", osc_en, 0);
        exit_int = 1; cyc(1); exit_int = 0; cyc(1);
        chk("R8 int exit scm", mode, 0);

        // R6 debug keeps clocks
        dbg = 1; pulse_stop(); dbg = 0;
        chk("R6 mode", mode, 0);
        chk("R6 feed", feed, 1);

        // R7 keep-alive, R12 engaged external before qualification
        wr_cfg(2'b11, 3'd6, 1); cyc(2);
        chk("R2 fee", mode, 3);
        chk("R12 fee internal", ref_src, 0);
        chk("R12 fee feed", feed, 1);
        pulse_stop();
        chk("R7 mode", mode, 4);
        chk("R7 feed", feed, 0);
        chk("R7 dco_en", dco_en, 1);
        chk("R7 osc_en", osc_en, 1);
        dco_stable = 0; cyc(4);
        exit_int = 1; cyc(1); exit_int = 0; cyc(1);
        chk("R8 x1 temp scm", mode, 0);
        chk("R8 sel kept", sel, 3);
        chk("R8 div kept", div_sel, 6);
        dco_stable = 1; cyc(5);
        chk("R8 fee after stable", mode, 3);

        // R9 reset exit keeps trim only
        trim_data = 8'hA5; trim_wr = 1; cyc(1); trim_wr = 0;
        wr_cfg(2'b00, 3'd6, 1); cyc(2);
        flt_data = 9'd99; flt_wr = 1; cyc(1); flt_wr = 0;
        pulse_stop();
        exit_rst = 1; cyc(1); exit_rst = 0; cyc(1);
        chk("R9 mode", mode, 0);
        chk("R9 sel", sel, 0);
        chk("R9 dco", dco_code, DCO_DEF);
        chk("R9 div", div_sel, 0);
        chk("R9 trim", trim, 8'hA5);
        pulse_stop();
        chk("R9 keep cleared", dco_en, 0);
        exit_int = 1; cyc(1); exit_int = 0; cyc(1);

        // R8 interrupt exit into bypassed external, reference requalified
        wr_cfg(2'b10, 3'd0, 0); cyc(3);
        pulse_stop();
        exit_int = 1; cyc(1); exit_int = 0; cyc(1);
        chk("R8 fbe resume", mode, 2);
        chk("R8 fbe resume gated", feed, 0);
        wr_cfg(2'b00, 3'd0, 0); cyc(2);

        // Random sweep: R2 R3 R4
        void'($urandom(32'd1234));
        exp_dco = dco_code;
        for (int t = 0; t < 200; t++) begin
            logic [1:0] s;
            s = 2'($urandom_range(0, 3));
            dco_stable = 1'($urandom_range(0, 1));
            ext_det = 1'($urandom_range(0, 1));
            loss = 1'($urandom_range(0, 1));
            wr_cfg(s, 3'($urandom_range(0, 7)), 0);
            cyc(6);
            chk("R2 R3 random mode", mode, exp_mode(s, dco_stable, ext_det, loss));
            flt_data = 9'($urandom_range(0, 511)); flt_wr = 1;
            cyc(1); flt_wr = 0;
            if (exp_mode(s, dco_stable, ext_det, loss) == 0) exp_dco = flt_data;
            chk("R4 random dco", dco_code, exp_dco);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule